// File: doc/BRIEF.md
# SDRAM Read Burst Output Pipeline

This block models the device-side data output path of a single-data-rate SDRAM. Each clock it takes at most one decoded command (read, write or precharge), a DQM mask bit and a CAS latency setting. A read starts a burst of consecutive column words taken from a small internal word array. The words leave on a modelled DQ bus together with an output enable, the first one exactly CAS-latency clocks after the read command.

A burst can be cut short at any cycle. A later read replaces the running burst, and words already in flight still come out. A precharge that hits the burst's bank, or hits every bank, stops new words from being issued. A write clears the whole output path, so the bus is released at once for incoming data. DQM acts on the output enable with a fixed two-clock lag. Cycle n below means the clock period in which an input is presented, and it is sampled at the rising edge that ends that period.

Top module: `sdram_rd_pipe`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `dq_oe` is 0 and `dq_out` is 0. Commands presented during reset leave no burst pending.
- R2: A read in cycle n with `cas_lat` = L (2 or 3) drives its first word with `dq_oe` = 1 in cycle n+L.
- R3: A burst delivers 4 words in 4 consecutive cycles. Column bits [1:0] count up from the start column and wrap, while the upper column bits and the bank stay fixed. After the fourth word `dq_oe` returns to 0.
- R4: The word at bank b, column c equals ((b*32 + c)*37 + 11) mod 65536.
- R5: `dqm` high in cycle n forces `dq_oe` = 0 and `dq_out` = 0 in cycle n+2. The burst still advances past the masked word.
- R6: A read in cycle m during a burst, to either bank, stops the old burst. Old words due before cycle m+L still appear, and the new burst starts in cycle m+L.
- R7: A write in cycle m with no read that cycle stops the burst, and no word is driven from cycle m+1 until a later read.
- R8: A precharge in cycle m with `pre_all` = 1, or with `pre_bank` equal to the burst's bank, stops the burst. The last old word is the one due in cycle m+L-1. A precharge of the other bank has no effect.
- R9: When several commands arrive in one cycle, read wins over write, and write wins over precharge.
- R10: Whenever no word is scheduled, `dq_oe` is 0 and `dq_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_cmd | input | 1 | Read command this cycle |
| rd_bank | input | BANK_W | Bank of the read |
| rd_col | input | COL_W | Start column of the read |
| wr_cmd | input | 1 | Write command this cycle |
| pre_cmd | input | 1 | Precharge command this cycle |
| pre_all | input | 1 | Precharge addresses every bank |
| pre_bank | input | BANK_W | Bank of a single-bank precharge |
| dqm | input | 1 | Output mask, acts two clocks later |
| cas_lat | input | CL_W | CAS latency, 2 or 3 |
| dq_out | output | DATA_W | Driven data word, 0 when not enabled |
| dq_oe | output | 1 | DQ output enable |

## Verification
A wrong burst counter or column register shows up at the ports within one burst. The symptoms are a fifth word, a missing word, or a word from outside the aligned four-word block, all visible at most L+4 cycles after the read. A stale delay-line stage or mask register shows up two or three cycles after the bad state arises, either as a word leaking after a write or as a word driven through a DQM high. The bench therefore compares `dq_oe` and `dq_out` against an arithmetic schedule on every cycle. It sweeps every start column, both banks, both latencies, every interrupt gap and all 64 mask patterns over a burst window.

// File: rtl/sdram_rd_pkg.sv
// Shared definitions for the SDRAM read output path.
// Assumes: single command decode per cycle, priority read > write > precharge.
package sdram_rd_pkg;

    // Command class the burst generator acts on in a cycle.
    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2,
        CMD_STOP  = 2'd3
    } rd_cmd_e;

    // Content pattern of the modelled word array: word = addr*MUL + ADD.
    localparam int PAT_MUL = 37;
    localparam int PAT_ADD = 11;

endpackage

// File: rtl/sdram_rd_word_store.sv
// Read-only word array addressed by {bank, column}.
// Contents are computed from the package pattern; lookup is combinational.
// Assumes: 2**ADDR_W stays small (a few hundred words at most).
module sdram_rd_word_store
    import sdram_rd_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] tbl [DEPTH];

    // Fill each entry from the address pattern.
    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_word
            assign tbl[i] = DATA_W'(i * PAT_MUL + PAT_ADD);
        end
    endgenerate

    // Select the addressed word.
    assign rdata = tbl[raddr];

endmodule

// File: rtl/sdram_rd_burst_gen.sv
// Burst generator: holds the running burst and issues one word address per
// cycle, starting the cycle after the read is sampled. Reads restart it,
// writes and matching precharges stop it. A write also raises `kill` so the
// latency pipe drops words already in flight.
// Assumes: BL is a power of two, 2 <= BL < 2**COL_W.
module sdram_rd_burst_gen
    import sdram_rd_pkg::*;
#(
    parameter int BANK_W = 1,
    parameter int COL_W  = 5,
    parameter int BL     = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_cmd,
    input  logic [BANK_W-1:0]        rd_bank,
    input  logic [COL_W-1:0]         rd_col,
    input  logic                     wr_cmd,
    input  logic                     pre_cmd,
    input  logic                     pre_all,
    input  logic [BANK_W-1:0]        pre_bank,
    output logic                     beat_vld,
    output logic [BANK_W+COL_W-1:0]  beat_addr,
    output logic                     kill
);
    localparam int OFS_W = $clog2(BL);

    rd_cmd_e           cmd_e;
    logic              busy_q;
    logic [OFS_W-1:0]  left_q;
    logic [BANK_W-1:0] bank_q;
    logic [COL_W-1:0]  col_q;
    logic [OFS_W-1:0]  ofs_nxt;

    // Decode this cycle's command with read > write > precharge priority.
    always_comb begin
        cmd_e = CMD_NONE;
        if (rd_cmd) begin
            cmd_e = CMD_READ;
        end else if (wr_cmd) begin
            cmd_e = CMD_WRITE;
        end else if (pre_cmd && (pre_all || pre_bank == bank_q)) begin
            cmd_e = CMD_STOP;
        end
    end

    // Next position inside the aligned burst block.
    assign ofs_nxt = col_q[OFS_W-1:0] + OFS_W'(1);

    // Burst state: start, advance, finish or abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            left_q <= '0;
            bank_q <= '0;
            col_q  <= '0;
        end else begin
            case (cmd_e)
                CMD_READ: begin
                    busy_q <= 1'b1;
                    bank_q <= rd_bank;
                    col_q  <= rd_col;
                    left_q <= OFS_W'(BL - 1);
                end
                CMD_WRITE, CMD_STOP: begin
                    busy_q <= 1'b0;
                end
                default: begin
                    if (busy_q) begin
                        if (left_q == '0) begin
                            busy_q <= 1'b0;
                        end else begin
                            left_q <= left_q - OFS_W'(1);
                            col_q  <= {col_q[COL_W-1:OFS_W], ofs_nxt};
                        end
                    end
                end
            endcase
        end
    end

    assign beat_vld  = busy_q;
    assign beat_addr = {bank_q, col_q};
    assign kill      = (cmd_e == CMD_WRITE);

    // R3: inside one burst the block base and bank hold, the offset steps by one.
    a_r3_block_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $past(busy_q) && $past(cmd_e) == CMD_NONE)
        |-> (col_q[COL_W-1:OFS_W] == $past(col_q[COL_W-1:OFS_W])
             && bank_q == $past(bank_q)
             && col_q[OFS_W-1:0] == $past(col_q[OFS_W-1:0]) + OFS_W'(1)));

    // R8: an all-bank precharge with no read leaves nothing to issue.
    a_r8_pre_all_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_cmd && pre_all && !rd_cmd) |=> !beat_vld);

endmodule

// File: rtl/sdram_rd_lat_pipe.sv
// Latency pipe: delays issued words so the first lands CAS-latency clocks
// after the read, applies the two-clock DQM mask and registers DQ and the
// output enable. `kill` empties every stage at the next edge.
// Assumes: MAX_CL >= 3; cas_lat changes only while no burst is in flight.
module sdram_rd_lat_pipe #(
    parameter int DATA_W = 16,
    parameter int MAX_CL = 3,
    parameter int CL_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat_vld,
    input  logic [DATA_W-1:0] beat_data,
    input  logic              kill,
    input  logic              dqm,
    input  logic [CL_W-1:0]   cas_lat,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);
    localparam int NSTG = MAX_CL - 2;

    logic              stg_vld [1:NSTG];
    logic [DATA_W-1:0] stg_dat [1:NSTG];
    logic              dqm_q;
    int                lat_i;
    logic              tap_vld;
    logic [DATA_W-1:0] tap_dat;
    logic              drive;

    // Clamp the latency setting into the supported range.
    always_comb begin
        lat_i = int'(cas_lat);
        if (lat_i < 2) lat_i = 2;
        if (lat_i > MAX_CL) lat_i = MAX_CL;
    end

    // Delay stages; stage k holds a word issued k cycles ago.
    generate
        for (genvar k = 1; k <= NSTG; k++) begin : g_stg
            always_ff @(posedge clk) begin
                if (!rst_n || kill) begin
                    stg_vld[k] <= 1'b0;
                    stg_dat[k] <= '0;
                end else if (k == 1) begin
                    stg_vld[k] <= beat_vld;
                    stg_dat[k] <= beat_data;
                end else begin
                    stg_vld[k] <= stg_vld[k-1];
                    stg_dat[k] <= stg_dat[k-1];
                end
            end
        end
    endgenerate

    // Pick the stage that matches the configured latency.
    always_comb begin
        tap_vld = beat_vld;
        tap_dat = beat_data;
        for (int k = 1; k <= NSTG; k++) begin
            if (lat_i == k + 2) begin
                tap_vld = stg_vld[k];
                tap_dat = stg_dat[k];
            end
        end
    end

    // First half of the two-clock DQM lag.
    always_ff @(posedge clk) begin
        if (!rst_n) dqm_q <= 1'b0;
        else        dqm_q <= dqm;
    end

    assign drive = tap_vld && !dqm_q;

    // Output register: DQ word and enable, zero when idle, masked or flushed.
    always_ff @(posedge clk) begin
        if (!rst_n || kill) begin
            dq_oe  <= 1'b0;
            dq_out <= '0;
        end else begin
            dq_oe  <= drive;
            dq_out <= drive ? tap_dat : '0;
        end
    end

    // R5: an enabled word never follows a DQM high two clocks earlier.
    a_r5_dqm_lag: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> !$past(dqm, 2));

    // R7: the cycle after a write flush the bus is released.
    a_r7_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(kill) |-> !dq_oe);

    // R1: reset leaves the outputs dark.
    a_r1_reset_dark: assert property (@(posedge clk)
        !rst_n |=> (!dq_oe && dq_out == '0));

endmodule

// File: rtl/sdram_rd_pipe.sv
// Top of the SDRAM read output path: burst generator, word store and
// latency pipe. Inputs are decoded commands sampled on the rising edge.
// Assumes: at most one meaningful command per cycle (priority resolves ties).
module sdram_rd_pipe #(
    parameter int BANK_W = 1,
    parameter int COL_W  = 5,
    parameter int DATA_W = 16,
    parameter int BL     = 4,
    parameter int MAX_CL = 3,
    parameter int CL_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_cmd,
    input  logic [BANK_W-1:0] rd_bank,
    input  logic [COL_W-1:0]  rd_col,
    input  logic              wr_cmd,
    input  logic              pre_cmd,
    input  logic              pre_all,
    input  logic [BANK_W-1:0] pre_bank,
    input  logic              dqm,
    input  logic [CL_W-1:0]   cas_lat,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);
    localparam int ADDR_W = BANK_W + COL_W;

    logic              beat_vld;
    logic [ADDR_W-1:0] beat_addr;
    logic [DATA_W-1:0] beat_data;
    logic              kill;

    sdram_rd_burst_gen #(
        .BANK_W (BANK_W),
        .COL_W  (COL_W),
        .BL     (BL)
    ) u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_cmd    (rd_cmd),
        .rd_bank   (rd_bank),
        .rd_col    (rd_col),
        .wr_cmd    (wr_cmd),
        .pre_cmd   (pre_cmd),
        .pre_all   (pre_all),
        .pre_bank  (pre_bank),
        .beat_vld  (beat_vld),
        .beat_addr (beat_addr),
        .kill      (kill)
    );

    sdram_rd_word_store #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_store (
        .raddr (beat_addr),
        .rdata (beat_data)
    );

    sdram_rd_lat_pipe #(
        .DATA_W (DATA_W),
        .MAX_CL (MAX_CL),
        .CL_W   (CL_W)
    ) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .beat_vld  (beat_vld),
        .beat_data (beat_data),
        .kill      (kill),
        .dqm       (dqm),
        .cas_lat   (cas_lat),
        .dq_out    (dq_out),
        .dq_oe     (dq_oe)
    );

endmodule

// File: tb/sdram_rd_pipe_tb.sv
// Cycle-scheduled bench: every command updates an expected output schedule
// computed from the requirements; outputs are compared at each falling edge.
module sdram_rd_pipe_tb;
    localparam int NT = 8192;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_cmd = 1'b0;
    logic [0:0]  rd_bank = '0;
    logic [4:0]  rd_col = '0;
    logic        wr_cmd = 1'b0;
    logic        pre_cmd = 1'b0;
    logic        pre_all = 1'b0;
    logic [0:0]  pre_bank = '0;
    logic        dqm = 1'b0;
    logic [1:0]  cas_lat = 2'd2;
    logic [15:0] dq_out;
    logic        dq_oe;

    int    checks = 0;
    int    fails = 0;
    int    t = 0;
    int    lat = 2;
    int    cur_bank = 0;
    bit    done = 1'b0;
    bit    rst_next = 1'b0;
    string tag = "R1";

    bit          ev [NT];
    bit          em [NT];
    logic [15:0] ew [NT];

    sdram_rd_pipe u_dut (
        .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd), .rd_bank(rd_bank),
        .rd_col(rd_col), .wr_cmd(wr_cmd), .pre_cmd(pre_cmd), .pre_all(pre_all),
        .pre_bank(pre_bank), .dqm(dqm), .cas_lat(cas_lat),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    always #10 clk = ~clk;

    // R4 word formula.
    function automatic logic [15:0] word_of(int b, int c);
        return 16'((b * 32 + c) * 37 + 11);
    endfunction

    function automatic void clr(int from, int upto);
        for (int j = from; j <= upto; j++) ev[j] = 1'b0;
    endfunction

    // One cycle: compare cycle t outputs, drive cycle t inputs, update schedule.
    task automatic step(bit rd, int rb, int rc, bit wr, bit pr, bit pa, int pb, bit dm);
        bit          e_oe;
        logic [15:0] e_dq;
        @(negedge clk);
        e_oe = ev[t] && !em[t];
        e_dq = e_oe ? ew[t] : 16'h0;
        checks++;
        if (dq_oe !== e_oe || dq_out !== e_dq) begin
            fails++;
            $display("FAIL %s cycle %0d: oe=%b dq=%h expected oe=%b dq=%h",
                     tag, t, dq_oe, dq_out, e_oe, e_dq);
        end
        rst_n    = rst_next;
        rd_cmd   = rd;
        rd_bank  = 1'(rb);
        rd_col   = 5'(rc);
        wr_cmd   = wr;
        pre_cmd  = pr;
        pre_all  = pa;
        pre_bank = 1'(pb);
        dqm      = dm;
        cas_lat  = 2'(lat);
        if (rst_next) begin
            if (rd) begin
                clr(t + lat, t + lat + 12);
                for (int k = 0; k < 4; k++) begin
                    ev[t + lat + k] = 1'b1;
                    ew[t + lat + k] = word_of(rb, (rc & 28) | ((rc + k) & 3));
                end
                cur_bank = rb;
            end else if (wr) begin
                clr(t + 1, t + 12);
            end else if (pr && (pa || pb == cur_bank)) begin
                clr(t + lat, t + 12);
            end
            if (dm) em[t + 2] = 1'b1;
        end
        t++;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NT; i++) begin
            ev[i] = 1'b0;
            em[i] = 1'b0;
            ew[i] = '0;
        end
        // R1: reset with commands presented, then release.
        tag = "R1";
        rst_next = 1'b0;
        for (int i = 0; i < 4; i++) step(1, 1, 7, 0, 0, 0, 0, 1);
        rst_next = 1'b1;
        idle(6);

        // R2 R3 R4 R10: every column, both banks, both latencies.
        tag = "R2 R3 R4 R10";
        for (int l = 2; l <= 3; l++) begin
            lat = l;
            idle(2);
            for (int b = 0; b < 2; b++)
                for (int c = 0; c < 32; c++) begin
                    step(1, b, c, 0, 0, 0, 0, 0);
                    idle(8);
                end
        end

        // R5: all 6-bit DQM patterns across the burst window.
        tag = "R5";
        for (int l = 2; l <= 3; l++) begin
            lat = l;
            idle(2);
            for (int p = 0; p < 64; p++) begin
                step(1, p & 1, p % 32, 0, 0, 0, 0, p[0]);
                for (int k = 1; k < 6; k++) step(0, 0, 0, 0, 0, 0, 0, p[k]);
                idle(4);
            end
        end

        // R6: read interrupted by read, every gap, same and other bank.
        tag = "R6";
        for (int l = 2; l <= 3; l++) begin
            lat = l;
            idle(2);
            for (int g = 1; g <= 5; g++)
                for (int b = 0; b < 2; b++) begin
                    step(1, 0, 5, 0, 0, 0, 0, 0);
                    idle(g - 1);
                    step(1, b, 17, 0, 0, 0, 0, 0);
                    idle(9);
                end
            // R6: a new read on every cycle.
            for (int c = 0; c < 6; c++) step(1, c & 1, c * 5, 0, 0, 0, 0, 0);
            idle(9);
        end

        // R7: write truncation at every gap.
        tag = "R7";
        for (int l = 2; l <= 3; l++) begin
            lat = l;
            idle(2);
            for (int g = 0; g <= 6; g++) begin
                step(1, 1, 22, 0, 0, 0, 0, 0);
                idle(g);
                step(0, 0, 0, 1, 0, 0, 0, 0);
                idle(8);
            end
        end

        // R8: precharge of burst bank, other bank, all banks.
        tag = "R8";
        for (int l = 2; l <= 3; l++) begin
            lat = l;
            idle(2);
            for (int g = 0; g <= 5; g++)
                for (int m = 0; m < 3; m++) begin
                    step(1, 1, 9, 0, 0, 0, 0, 0);
                    idle(g);
                    step(0, 0, 0, 0, 1, m == 2, (m == 1) ? 0 : 1, 0);
                    idle(8);
                end
        end

        // R9: simultaneous commands resolve read > write > precharge.
        tag = "R9";
        for (int l = 2; l <= 3; l++) begin
            lat = l;
            idle(2);
            step(1, 0, 3, 1, 0, 0, 0, 0);
            idle(8);
            step(1, 1, 30, 0, 1, 1, 0, 0);
            idle(8);
            step(1, 0, 12, 0, 0, 0, 0, 0);
            step(0, 0, 0, 0, 0, 0, 0, 0);
            step(1, 1, 14, 1, 1, 1, 1, 0);
            idle(8);
            step(1, 0, 12, 0, 0, 0, 0, 0);
            step(0, 0, 0, 1, 1, 1, 0, 0);
            idle(8);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule